// File: doc/BRIEF.md
# Pin Sequencer Register Front End

This block is the memory-mapped slave that sits between a processor bus and a pin sequencer. A software driver talks to it through a 12-bit address space with 32-bit data, using an APB-style two-phase handshake: a setup cycle, then an access cycle that always completes at once. The block answers identification and self-description reads, so that one driver can adapt to any build of the core. It also holds the divider and read-delay settings that the sequencer runs with.

Commands and results move through two FIFOs held inside the block. Software writes a 32-bit command word to one shared data address, and that word leaves through a valid/ready port to the sequencer. The sequencer returns 16-bit results through a second valid/ready port. Software reads those results from the same shared address, and a flag bit in the read word tells it whether an entry was actually returned. A status word reports how many results are waiting and how much command space is left. With these fill levels, a driver can batch its traffic without polling on every word.

Top module: `pseq_mmio`

## Requirements
- R1: Address 0x000 reads 0x0008_0001: interface revision 0 in bits 31–24, identification length 8 in bits 23–16, core number 1 in bits 15–0. Address 0x004 reads 0x0100_0000: major 1 in bits 31–24, minor 0 in bits 23–16, patch 0 in bits 15–0.
- R2: Address 0x008 reads the input-buffer depth in bits 31–24, the divider width in bits 23–16, the command data-field width in bits 15–8 and the pin count in bits 7–0. Address 0x00C reads the result FIFO depth in bits 15–8 and the command FIFO depth in bits 7–0. Bit 0 of address 0x010 is 1 exactly when the divider is bus-writable.
- R3: A completed write to 0x014 appends the whole 32-bit write word to the command FIFO. Commands appear on `cmd_data_o` with `cmd_valid_o` high, in write order, and one is removed on each rising edge where `cmd_valid_o` and `cmd_ready_i` are both high.
- R4: A read of 0x014 while results are waiting returns the oldest result in bits 15–0 with bit 16 set, and removes that result at the end of the access.
- R5: A read of 0x014 with no results waiting returns 0, including bit 16 clear, and leaves the result FIFO empty.
- R6: A command write while the command FIFO is full is discarded: no stored command changes, and the vacancy field stays at 0.
- R7: Address 0x018 reads the number of stored results in bits 31–24 and the number of free command slots in bits 23–16, with all other bits 0.
- R8: Address 0x01C (divider, low DIV_W bits) and address 0x020 (read delay, low DLY_W bits) reset to their init parameters, read back zero-extended, and drive `clk_div_o` and `rd_delay_o`. A write takes effect from the next clock when it is permitted.
- R9: When the permission parameter DIV_WRITABLE is 0, writes to 0x01C leave the divider at its init value, while the read-delay register stays writable.
- R10: Reads of any address other than those above return 0, and writes to them change no register, no FIFO and no output.
- R11: `rsp_ready_o` is high exactly while the result FIFO has a free slot, and a result is stored on each rising edge where `rsp_valid_i` and `rsp_ready_o` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase of a transfer |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, decoded from `paddr` |
| pready | output | 1 | Always 1, so every transfer completes in its access cycle |
| cmd_valid_o | output | 1 | A command is waiting for the sequencer |
| cmd_ready_i | input | 1 | Sequencer takes the command on this edge |
| cmd_data_o | output | 32 | Oldest command word |
| rsp_valid_i | input | 1 | Sequencer offers a result |
| rsp_ready_o | output | 1 | Result FIFO has space |
| rsp_data_i | input | 16 | Result payload |
| clk_div_o | output | DIV_W | Current divider setting |
| rd_delay_o | output | DLY_W | Current read-delay setting |

## Verification
The assertions assume that a transfer follows the two-phase handshake: `penable` is high only in the cycle after a setup cycle, and `paddr`, `pwrite` and `pwdata` hold steady across both phases. They also assume that the sequencer keeps `rsp_valid_i` low whenever it is about to offer a result that `rsp_ready_o` would refuse, unless a test means to drive overflow. The stimulus tasks keep every transfer to exactly one setup cycle and one access cycle. They hold `rsp_valid_i` low during bus reads, so that each expected read word follows from a state that does not move underneath it. A reference model built on queues tracks both FIFOs and both settings on every edge. A second instance, with the divider locked and non-zero init values, shares the same bus stimulus.

// File: rtl/pseq_mmio_pkg.sv
package pseq_mmio_pkg;

   localparam logic [11:0] A_IDENT   = 12'h000;
   localparam logic [11:0] A_VERSION = 12'h004;
   localparam logic [11:0] A_SHAPE   = 12'h008;
   localparam logic [11:0] A_DEPTHS  = 12'h00C;
   localparam logic [11:0] A_PERMIT  = 12'h010;
   localparam logic [11:0] A_DATA    = 12'h014;
   localparam logic [11:0] A_LEVELS  = 12'h018;
   localparam logic [11:0] A_DIVIDER = 12'h01C;
   localparam logic [11:0] A_DELAY   = 12'h020;

   localparam logic [7:0]  IF_REVISION = 8'd0;
   localparam logic [7:0]  IDENT_BYTES = 8'd8;
   localparam logic [15:0] CORE_NUMBER = 16'd1;
   localparam logic [7:0]  VER_MAJOR   = 8'd1;
   localparam logic [7:0]  VER_MINOR   = 8'd0;
   localparam logic [15:0] VER_PATCH   = 16'd0;

   localparam int RESULT_W = 16;
   localparam int VALID_BIT = 16;

endpackage

// File: rtl/pseq_fifo.sv
module pseq_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 16,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [W-1:0]  in_data,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [W-1:0]  out_data,
   output logic [LW-1:0] level
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

   logic [W-1:0]  store [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [LW-1:0] count;
   logic          push, pop;

   assign in_ready  = (count != DEPTH_L);
   assign out_valid = (count != '0);
   assign push      = in_valid && in_ready;
   assign pop       = out_ready && out_valid;
   assign out_data  = store[rd_ptr];
   assign level     = count;

   always_ff @(posedge clk) begin
      if (push) store[wr_ptr] <= in_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + PW'(1);
         if (pop)  rd_ptr <= rd_ptr + PW'(1);
         count <= count + LW'(push) - LW'(pop);
      end
   end

   // R6: the fill level never passes the depth
   a_r6_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= DEPTH_L);

   // R4: a lone removal lowers the level by exactly one
   a_r4_pop_lowers: assert property (@(posedge clk) disable iff (!rst_n)
      (out_ready && out_valid && !in_valid) |=> (count == $past(count) - LW'(1)));

endmodule

// File: rtl/pseq_cfg_reg.sv
module pseq_cfg_reg #(
   parameter int W        = 20,
   parameter int INIT     = 0,
   parameter bit WRITABLE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] value
);
   generate
      if (WRITABLE) begin : g_rw
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     value <= W'(INIT);
            else if (wr_en) value <= wr_data;
         end
      end else begin : g_locked
         logic unused_inputs;
         assign unused_inputs = ^{clk, rst_n, wr_en, wr_data};
         assign value = W'(INIT);
      end
   endgenerate

endmodule

// File: rtl/pseq_mmio.sv
module pseq_mmio
   import pseq_mmio_pkg::*;
#(
   parameter int PINS         = 1,
   parameter int DATA_W       = 24,
   parameter int DIV_W        = 20,
   parameter int DLY_W        = 8,
   parameter int RDBUF        = 2,
   parameter int CMD_DEPTH    = 16,
   parameter int RES_DEPTH    = 8,
   parameter int DIV_INIT     = 0,
   parameter int DLY_INIT     = 0,
   parameter bit DIV_WRITABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             psel,
   input  logic             penable,
   input  logic             pwrite,
   input  logic [11:0]      paddr,
   input  logic [31:0]      pwdata,
   output logic [31:0]      prdata,
   output logic             pready,
   output logic             cmd_valid_o,
   input  logic             cmd_ready_i,
   output logic [31:0]      cmd_data_o,
   input  logic             rsp_valid_i,
   output logic             rsp_ready_o,
   input  logic [15:0]      rsp_data_i,
   output logic [DIV_W-1:0] clk_div_o,
   output logic [DLY_W-1:0] rd_delay_o
);
   localparam int CMD_LW = $clog2(CMD_DEPTH + 1);
   localparam int RES_LW = $clog2(RES_DEPTH + 1);
   localparam logic [CMD_LW-1:0] CMD_DEPTH_L = CMD_LW'(CMD_DEPTH);

   // elaboration-time parameter checks
   generate
      if (PINS < 1 || PINS > 255) begin : g_bad_pins
         $error("PINS must be within 1..255");
      end
      if (CMD_DEPTH < 2 || CMD_DEPTH > 128 || (CMD_DEPTH & (CMD_DEPTH - 1)) != 0) begin : g_bad_cmd
         $error("CMD_DEPTH must be a power of two within 2..128");
      end
      if (RES_DEPTH < 2 || RES_DEPTH > 128 || (RES_DEPTH & (RES_DEPTH - 1)) != 0) begin : g_bad_res
         $error("RES_DEPTH must be a power of two within 2..128");
      end
      if (DIV_W < 1 || DIV_W > 32 || DLY_W < 1 || DLY_W > 32) begin : g_bad_cfg
         $error("DIV_W and DLY_W must be within 1..32");
      end
      if (DATA_W < 1 || DATA_W > 255 || RDBUF < 0 || RDBUF > 255) begin : g_bad_misc
         $error("DATA_W or RDBUF out of range");
      end
   endgenerate

   logic access, wr_acc, rd_acc;
   logic wr_cmd, rd_res, wr_div, wr_dly;
   logic cmd_in_ready, res_valid;
   logic [15:0]       res_head;
   logic [CMD_LW-1:0] cmd_level, cmd_vacancy;
   logic [RES_LW-1:0] res_level;

   assign pready  = 1'b1;
   assign access  = psel && penable;
   assign wr_acc  = access && pwrite;
   assign rd_acc  = access && !pwrite;
   assign wr_cmd  = wr_acc && (paddr == A_DATA);
   assign rd_res  = rd_acc && (paddr == A_DATA);
   assign wr_div  = wr_acc && (paddr == A_DIVIDER);
   assign wr_dly  = wr_acc && (paddr == A_DELAY);

   pseq_fifo #(.W(32), .DEPTH(CMD_DEPTH)) u_cmd_fifo (
      .clk(clk), .rst_n(rst_n),
      .in_valid(wr_cmd), .in_ready(cmd_in_ready), .in_data(pwdata),
      .out_valid(cmd_valid_o), .out_ready(cmd_ready_i), .out_data(cmd_data_o),
      .level(cmd_level)
   );

   pseq_fifo #(.W(RESULT_W), .DEPTH(RES_DEPTH)) u_res_fifo (
      .clk(clk), .rst_n(rst_n),
      .in_valid(rsp_valid_i), .in_ready(rsp_ready_o), .in_data(rsp_data_i),
      .out_valid(res_valid), .out_ready(rd_res), .out_data(res_head),
      .level(res_level)
   );

   pseq_cfg_reg #(.W(DIV_W), .INIT(DIV_INIT), .WRITABLE(DIV_WRITABLE)) u_div_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_div), .wr_data(pwdata[DIV_W-1:0]),
      .value(clk_div_o)
   );

   pseq_cfg_reg #(.W(DLY_W), .INIT(DLY_INIT), .WRITABLE(1'b1)) u_dly_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_dly), .wr_data(pwdata[DLY_W-1:0]),
      .value(rd_delay_o)
   );

   assign cmd_vacancy = CMD_DEPTH_L - cmd_level;

   always_comb begin
      unique case (paddr)
         A_IDENT:   prdata = {IF_REVISION, IDENT_BYTES, CORE_NUMBER};
         A_VERSION: prdata = {VER_MAJOR, VER_MINOR, VER_PATCH};
         A_SHAPE:   prdata = {8'(RDBUF), 8'(DIV_W), 8'(DATA_W), 8'(PINS)};
         A_DEPTHS:  prdata = {16'd0, 8'(RES_DEPTH), 8'(CMD_DEPTH)};
         A_PERMIT:  prdata = {31'd0, DIV_WRITABLE};
         A_DATA:    prdata = res_valid ? {15'd0, 1'b1, res_head} : 32'd0;
         A_LEVELS:  prdata = {8'(res_level), 8'(cmd_vacancy), 16'd0};
         A_DIVIDER: prdata = 32'(clk_div_o);
         A_DELAY:   prdata = 32'(rd_delay_o);
         default:   prdata = 32'd0;
      endcase
   end

   // R5: reading the empty result FIFO leaves it empty
   a_r5_empty_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_res && !res_valid && !rsp_valid_i) |=> (res_level == '0));

   // R6: a refused command write does not alter the stored count
   a_r6_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmd && !cmd_in_ready && !cmd_ready_i) |=> $stable(cmd_level));

   // R3: an accepted write with no removal raises the command level by one
   a_r3_push_raises: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmd && cmd_in_ready && !cmd_ready_i) |=> (cmd_level == $past(cmd_level) + CMD_LW'(1)));

   generate
      if (DIV_WRITABLE) begin : g_div_chk_rw
         // R8: a permitted divider write is visible on the next clock
         a_r8_div_loads: assert property (@(posedge clk) disable iff (!rst_n)
            wr_div |=> (clk_div_o == $past(pwdata[DIV_W-1:0])));
      end else begin : g_div_chk_locked
         // R9: a denied divider write leaves the output unchanged
         a_r9_div_locked: assert property (@(posedge clk) disable iff (!rst_n)
            wr_div |=> $stable(clk_div_o));
      end
   endgenerate

   // R8: the read-delay register takes every write
   a_r8_dly_loads: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dly |=> (rd_delay_o == $past(pwdata[DLY_W-1:0])));

endmodule

// File: tb/pseq_mmio_bench.sv
module pseq_mmio_bench;
   localparam int DIV_W = 20;
   localparam int DLY_W = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic        cmd_ready = 1'b0;
   logic        rsp_valid = 1'b0;
   logic [15:0] rsp_data = '0;

   logic [31:0]      prdata, prdata_ro, cmd_data, cmd_data_ro;
   logic             pready, pready_ro, cmd_valid, cmd_valid_ro, rsp_ready, rsp_ready_ro;
   logic [DIV_W-1:0] clk_div, clk_div_ro;
   logic [DLY_W-1:0] rd_delay, rd_delay_ro;

   int checks = 0;
   int failures = 0;
   bit started = 0;

   always #5 clk = ~clk;

   pseq_mmio u_pseq_mmio (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
      .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_data_o(cmd_data),
      .rsp_valid_i(rsp_valid), .rsp_ready_o(rsp_ready), .rsp_data_i(rsp_data),
      .clk_div_o(clk_div), .rd_delay_o(rd_delay)
   );

   pseq_mmio #(.DIV_INIT(5), .DLY_INIT(3), .DIV_WRITABLE(1'b0)) u_pseq_mmio_ro (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata_ro), .pready(pready_ro),
      .cmd_valid_o(cmd_valid_ro), .cmd_ready_i(1'b1), .cmd_data_o(cmd_data_ro),
      .rsp_valid_i(1'b0), .rsp_ready_o(rsp_ready_ro), .rsp_data_i(16'h0),
      .clk_div_o(clk_div_ro), .rd_delay_o(rd_delay_ro)
   );

   // reference model
   logic [31:0] cq[$];
   logic [15:0] rq[$];
   int div_ref, dly_ref, dly_ro_ref;

   always @(posedge clk) begin
      if (!rst_n) begin
         cq.delete(); rq.delete();
         div_ref = 0; dly_ref = 0; dly_ro_ref = 3;
      end else begin
         automatic bit acc   = psel && penable;
         automatic bit cpop  = (cq.size() > 0) && cmd_ready;
         automatic bit cpush = acc && pwrite && paddr == 12'h014 && cq.size() < 16;
         automatic bit rpush = rsp_valid && rq.size() < 8;
         automatic bit rpop  = acc && !pwrite && paddr == 12'h014 && rq.size() > 0;
         if (cpop) void'(cq.pop_front());
         if (cpush) cq.push_back(pwdata);
         if (rpop) void'(rq.pop_front());
         if (rpush) rq.push_back(rsp_data);
         if (acc && pwrite && paddr == 12'h01C) div_ref = int'(pwdata[DIV_W-1:0]);
         if (acc && pwrite && paddr == 12'h020) begin
            dly_ref = int'(pwdata[DLY_W-1:0]);
            dly_ro_ref = int'(pwdata[DLY_W-1:0]);
         end
      end
   end

   function automatic logic [31:0] exp_read(logic [11:0] a);
      case (a)
         12'h000: return 32'h0008_0001;
         12'h004: return 32'h0100_0000;
         12'h008: return 32'h0214_1801;
         12'h00C: return 32'h0000_0810;
         12'h010: return 32'h0000_0001;
         12'h014: return (rq.size() > 0) ? {15'd0, 1'b1, rq[0]} : 32'd0;
         12'h018: return {8'(rq.size()), 8'(16 - cq.size()), 16'd0};
         12'h01C: return 32'(div_ref);
         12'h020: return 32'(dly_ref);
         default: return 32'd0;
      endcase
   endfunction

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && started) begin
         check("R3 cmd_valid", 32'(cmd_valid), 32'(cq.size() > 0));
         if (cq.size() > 0) check("R3 cmd_data order", cmd_data, cq[0]);
         check("R11 rsp_ready", 32'(rsp_ready), 32'(rq.size() < 8));
         check("R8 clk_div", 32'(clk_div), 32'(div_ref));
         check("R8 rd_delay", 32'(rd_delay), 32'(dly_ref));
         check("R9 locked divider", 32'(clk_div_ro), 32'd5);
         check("R9 delay on locked build", 32'(rd_delay_ro), 32'(dly_ro_ref));
      end
   end

   logic [31:0] last_rd, last_rd_ro, last_exp;

   task automatic bus(input bit w, input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      psel = 1'b1; penable = 1'b0; pwrite = w; paddr = a; pwdata = d;
      @(negedge clk);
      penable = 1'b1;
      #1;
      last_rd = prdata;
      last_rd_ro = prdata_ro;
      last_exp = exp_read(a);
      @(negedge clk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic rd_model(input logic [11:0] a, input string tag);
      bus(1'b0, a, 32'd0);
      check(tag, last_rd, last_exp);
   endtask

   task automatic rsp_burst(input int n, input logic [15:0] base);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rsp_valid = 1'b1; rsp_data = base + 16'(i);
      end
      @(negedge clk);
      rsp_valid = 1'b0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      started = 1;

      // R1, R2 identification and self description
      rd_model(12'h000, "R1 ident word");
      rd_model(12'h004, "R1 version word");
      rd_model(12'h008, "R2 shape word");
      rd_model(12'h00C, "R2 depth word");
      rd_model(12'h010, "R2 permit writable");
      check("R2 permit locked", last_rd_ro, 32'd0);

      // R7, R8 reset state
      rd_model(12'h018, "R7 levels at reset");
      check("R7 levels at reset literal", last_rd, 32'h0010_0000);
      rd_model(12'h01C, "R8 divider reset");
      check("R8 divider init on locked build", last_rd_ro, 32'd5);
      rd_model(12'h020, "R8 delay reset");
      check("R8 delay init on locked build", last_rd_ro, 32'd3);

      // R5 empty read
      rd_model(12'h014, "R5 empty read");
      check("R5 empty read literal", last_rd, 32'd0);
      rd_model(12'h018, "R5 levels after empty read");

      // R3 a few commands, held then released
      cmd_ready = 1'b0;
      bus(1'b1, 12'h014, 32'hC0DE_0001);
      bus(1'b1, 12'h014, 32'h1234_5678);
      bus(1'b1, 12'h014, 32'hFFFF_0003);
      rd_model(12'h018, "R7 vacancy after three writes");
      check("R7 vacancy literal", last_rd, 32'h000D_0000);
      @(negedge clk); cmd_ready = 1'b1;
      repeat (5) @(negedge clk);
      cmd_ready = 1'b0;
      check("R3 drained", 32'(cmd_valid), 32'd0);

      // R6 fill the command FIFO and overflow it
      for (int i = 0; i < 17; i++) bus(1'b1, 12'h014, 32'hA500_0000 + 32'(i));
      rd_model(12'h018, "R6 vacancy zero when full");
      check("R6 vacancy literal", last_rd, 32'h0000_0000);
      bus(1'b1, 12'h014, 32'hDEAD_BEEF);
      rd_model(12'h018, "R6 still full after dropped write");
      @(negedge clk); cmd_ready = 1'b1;
      repeat (20) @(negedge clk);
      cmd_ready = 1'b0;
      check("R6 exactly depth commands delivered", 32'(cmd_valid), 32'd0);

      // R4, R11 results
      rsp_burst(5, 16'h4100);
      rd_model(12'h018, "R7 occupancy five");
      for (int i = 0; i < 5; i++) rd_model(12'h014, "R4 result pop");
      rd_model(12'h014, "R5 empty after draining");
      rsp_burst(9, 16'h7700);
      check("R11 rsp_ready low when full", 32'(rsp_ready), 32'd0);
      rd_model(12'h018, "R7 occupancy full");
      check("R7 occupancy literal", last_rd, 32'h0810_0000);
      for (int i = 0; i < 8; i++) rd_model(12'h014, "R4 full drain pop");
      rd_model(12'h014, "R5 empty final");

      // R8, R9 configuration writes
      bus(1'b1, 12'h01C, 32'hFFFA_BCDE);
      rd_model(12'h01C, "R8 divider write");
      check("R9 divider locked readback", last_rd_ro, 32'd5);
      bus(1'b1, 12'h020, 32'h0000_017F);
      rd_model(12'h020, "R8 delay write truncated");
      check("R8 delay on locked build", last_rd_ro, 32'h7F);

      // R10 unmapped accesses
      bus(1'b1, 12'h024, 32'hFFFF_FFFF);
      bus(1'b1, 12'h016, 32'h1111_1111);
      bus(1'b1, 12'h018, 32'h2222_2222);
      bus(1'b1, 12'h000, 32'h3333_3333);
      rd_model(12'h024, "R10 unmapped read");
      check("R10 unmapped literal", last_rd, 32'd0);
      rd_model(12'h100, "R10 far unmapped read");
      rd_model(12'h016, "R10 misaligned read");
      rd_model(12'h018, "R10 levels unchanged");
      rd_model(12'h000, "R10 ident unchanged");
      rd_model(12'h01C, "R10 divider unchanged");
      check("R10 no command pushed", 32'(cmd_valid), 32'd0);

      repeat (3) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule